// File: doc/BRIEF.md
# Edge-Pulse Link with Refresh and Loss-of-Link Watchdog

This block carries a slowly changing bus line state (idle J, K, or single-ended zero) across a link that conveys only short pulses. The transmit half watches a two-bit line-state input and, whenever it changes, puts out a one-cycle pulse whose two-slot code names the new state. If the input stays put, the transmitter resends the present state as a refresh pulse every twelve bit times, so the far side stays correct even if a pulse was lost.

The receive half latches the state named by each incoming pulse and holds it until the next pulse. A watchdog counts bit times with no incoming pulse; after thirty-six of them it decides the sending side is dead and drops a link-good flag. While that flag is low, the recovered state reads as single-ended zero, and whatever drives the bus pins must hold its data drivers in high impedance and detach the pull-up. After power-up, or after the watchdog fires, the link is trusted again only once two pulses in a row have arrived.

Both halves share one clock and a one-cycle bit-time strobe. In a system, the transmit half of one die feeds the receive half of the other through the isolation barrier.

Top module: `iso_refresh_link`

## Requirements
- R1: Reset is synchronous and active low. During and after reset `tx_pulse` is 00, `rx_link_ok` is 0 and `rx_sym` is 00. The transmitter takes J as the last state it sent.
- R2: Line states on `tx_sym` and `rx_sym` are encoded SE0=00, J=01, K=10; 11 is illegal. Pulse codes on the link are J=01, K=10, SE0=11, and 00 means no pulse. When a legal `tx_sym` differs from the last state sent at a clock edge, `tx_pulse` carries that state's code for exactly the one following cycle.
- R3: If no pulse has been sent, each twelfth `bit_tick` since the last pulse sends a refresh pulse with the code of the last state sent. Refreshes therefore repeat every twelve bit times on a quiet line.
- R4: A state change at an edge where a refresh is also due produces one pulse, carrying the new state. The twelve-tick count restarts from that pulse.
- R5: `tx_sym` = 11 is ignored. It sends no pulse and does not change the state that later refreshes carry.
- R6: A nonzero code on `rx_pulse` sets the held state at the next edge. While `rx_link_ok` is 1, `rx_sym` shows the held state.
- R7: The thirty-sixth `bit_tick` with no pulse on `rx_pulse` since the last one clears `rx_link_ok`. While `rx_link_ok` is 0, `rx_sym` is 00 (drivers high impedance, pull-up detached).
- R8: A pulse that arrives in the same cycle as the expiring tick keeps the link up and restarts the thirty-six-tick count.
- R9: While `rx_link_ok` is 0, it rises on the second received pulse in a row. A watchdog expiry between the two pulses discards the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe once per bit time |
| tx_sym | input | 2 | Line state to transmit (SE0=00, J=01, K=10) |
| tx_pulse | output | 2 | Outgoing pulse code, 00 = no pulse |
| rx_pulse | input | 2 | Incoming pulse code, 00 = no pulse |
| rx_sym | output | 2 | Recovered line state, forced to 00 while the link is down |
| rx_link_ok | output | 1 | Link judged alive; low means drivers high-Z and pull-up detached |

## Verification
Two pairs of events can fall in the same cycle. On the transmit side, a state change can land exactly on the bit tick where a refresh is due. On the receive side, a pulse can arrive on the very tick that would expire the watchdog. The bench provokes the first by counting eleven quiet ticks and then switching the input on the twelfth. It provokes the second by injecting a pulse on the thirty-sixth tick after the previous one. In the first case it expects exactly one pulse, carrying the new state, followed by twelve more quiet ticks before the next refresh. In the second it expects the link to stay up and to drop only thirty-six ticks later.

// File: rtl/iso_link_pkg.sv
// Package: shared line-state and link-code definitions for the edge-pulse link.
// Assumes a two-slot parallel pulse code in which 00 means "no pulse".
package iso_link_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_BAD = 2'b11
    } line_sym_e;

    localparam logic [1:0] CODE_NONE = 2'b00;
    localparam logic [1:0] CODE_J    = 2'b01;
    localparam logic [1:0] CODE_K    = 2'b10;
    localparam logic [1:0] CODE_SE0  = 2'b11;

    // Map a legal line state to its pulse code.
    function automatic logic [1:0] sym_to_code(input logic [1:0] s);
        case (s)
            SYM_J:   sym_to_code = CODE_J;
            SYM_K:   sym_to_code = CODE_K;
            SYM_SE0: sym_to_code = CODE_SE0;
            default: sym_to_code = CODE_NONE;
        endcase
    endfunction

    // Map a nonzero pulse code back to its line state.
    function automatic logic [1:0] code_to_sym(input logic [1:0] c);
        case (c)
            CODE_J:  code_to_sym = SYM_J;
            CODE_K:  code_to_sym = SYM_K;
            default: code_to_sym = SYM_SE0;
        endcase
    endfunction

endpackage

// File: rtl/iso_bit_timer.sv
// Module: counts bit ticks since the last clear and flags the LIMIT-th one.
// Assumes: clear has priority over the tick; the count restarts on clear or on expiry.
module iso_bit_timer #(
    parameter int LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Expiry: the tick that would complete LIMIT quiet ticks.
    assign expire = tick && !clear && (cnt_q == LAST);

    // Tick counter with restart on clear or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/iso_edge_tx.sv
// Module: transmit half. Emits one pulse per legal state change and a refresh
// pulse after REFRESH_BITS quiet bit ticks.
// Assumes: an illegal input (11) is held off as "no change".
module iso_edge_tx
    import iso_link_pkg::*;
#(
    parameter int REFRESH_BITS = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic [1:0] sym_in,
    output logic [1:0] pulse_out
);
    line_sym_e  last_q;
    logic [1:0] pulse_q;
    logic       change;
    logic       refresh_due;

    // Change detect: legal input differing from the last state sent.
    assign change = (sym_in != SYM_BAD) && (sym_in != last_q);

    iso_bit_timer #(.LIMIT(REFRESH_BITS)) refresh_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (change),
        .tick   (bit_tick),
        .expire (refresh_due)
    );

    // Pulse register: change wins over refresh, otherwise idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= SYM_J;
            pulse_q <= CODE_NONE;
        end else if (change) begin
            last_q  <= line_sym_e'(sym_in);
            pulse_q <= sym_to_code(sym_in);
        end else if (refresh_due) begin
            pulse_q <= sym_to_code(last_q);
        end else begin
            pulse_q <= CODE_NONE;
        end
    end

    assign pulse_out = pulse_q;
endmodule

// File: rtl/iso_edge_rx.sv
// Module: receive half bistable. Holds the state named by the last pulse.
// Assumes: every nonzero code is a legal pulse.
module iso_edge_rx
    import iso_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pulse_in,
    output logic [1:0] held_sym,
    output logic       pulse_seen
);
    logic [1:0] held_q;

    assign pulse_seen = (pulse_in != CODE_NONE);

    // Bistable hold: update only when a pulse arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= SYM_SE0;
        end else if (pulse_seen) begin
            held_q <= code_to_sym(pulse_in);
        end
    end

    assign held_sym = held_q;
endmodule

// File: rtl/iso_link_watchdog.sv
// Module: loss-of-link watchdog with a consecutive-pulse revalidation streak.
// Assumes: a pulse in the expiring cycle counts as activity and wins.
module iso_link_watchdog #(
    parameter int WDOG_BITS      = 36,
    parameter int REVALID_PULSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic pulse_seen,
    output logic link_ok
);
    localparam int SW = $clog2(REVALID_PULSES + 1);
    localparam logic [SW-1:0] STREAK_LAST = SW'(REVALID_PULSES - 1);

    logic          ok_q;
    logic [SW-1:0] streak_q;
    logic          dead;

    iso_bit_timer #(.LIMIT(WDOG_BITS)) wdog_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pulse_seen),
        .tick   (bit_tick),
        .expire (dead)
    );

    // Link state: revalidate on a pulse streak, drop on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q     <= 1'b0;
            streak_q <= '0;
        end else if (pulse_seen) begin
            if (!ok_q) begin
                if (streak_q == STREAK_LAST) begin
                    ok_q     <= 1'b1;
                    streak_q <= '0;
                end else begin
                    streak_q <= streak_q + 1'b1;
                end
            end
        end else if (dead) begin
            ok_q     <= 1'b0;
            streak_q <= '0;
        end
    end

    assign link_ok = ok_q;
endmodule

// File: rtl/iso_refresh_link.sv
// Module: top of the edge-pulse link, transmit and receive halves side by side.
// Assumes: bit_tick is a single-cycle strobe shared by both halves.
module iso_refresh_link
    import iso_link_pkg::*;
#(
    parameter int REFRESH_BITS   = 12,
    parameter int WDOG_BITS      = 36,
    parameter int REVALID_PULSES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic [1:0] tx_sym,
    output logic [1:0] tx_pulse,
    input  logic [1:0] rx_pulse,
    output logic [1:0] rx_sym,
    output logic       rx_link_ok
);
    logic [1:0] held_sym;
    logic       pulse_seen;

    iso_edge_tx #(.REFRESH_BITS(REFRESH_BITS)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .sym_in    (tx_sym),
        .pulse_out (tx_pulse)
    );

    iso_edge_rx rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_in   (rx_pulse),
        .held_sym   (held_sym),
        .pulse_seen (pulse_seen)
    );

    iso_link_watchdog #(
        .WDOG_BITS      (WDOG_BITS),
        .REVALID_PULSES (REVALID_PULSES)
    ) wdog_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .pulse_seen (pulse_seen),
        .link_ok    (rx_link_ok)
    );

    // Output default: present SE0 while the link is judged dead.
    assign rx_sym = rx_link_ok ? held_sym : SYM_SE0;
endmodule

// File: rtl/iso_refresh_link_chk.sv
// Module: property checker for iso_refresh_link, attached by bind.
module iso_refresh_link_chk
    import iso_link_pkg::*;
#(
    parameter int REFRESH_BITS = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic [1:0] tx_sym,
    input logic [1:0] tx_pulse,
    input logic [1:0] rx_pulse,
    input logic [1:0] rx_sym,
    input logic       rx_link_ok
);
    localparam int GW = $clog2(REFRESH_BITS + 2);
    logic [GW-1:0] gap_q;

    // Ticks observed since the last transmitted pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tx_pulse != CODE_NONE) begin
            gap_q <= '0;
        end else if (bit_tick && gap_q <= GW'(REFRESH_BITS)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_TX_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pulse != CODE_NONE && $past(tx_sym) != SYM_BAD) |-> tx_pulse == sym_to_code($past(tx_sym))); // R2
    AST_REFRESH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(REFRESH_BITS)); // R3
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_sym) == SYM_BAD && !$past(bit_tick)) |-> tx_pulse == CODE_NONE); // R5
    AST_RX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_pulse) != CODE_NONE && rx_link_ok) |-> rx_sym == code_to_sym($past(rx_pulse))); // R6
    AST_DROP_ON_QUIET_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_link_ok) |-> ($past(bit_tick) && $past(rx_pulse) == CODE_NONE)); // R7
    AST_RISE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_link_ok) |-> $past(rx_pulse) != CODE_NONE); // R9
endmodule

bind iso_refresh_link iso_refresh_link_chk #(.REFRESH_BITS(REFRESH_BITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .tx_sym     (tx_sym),
    .tx_pulse   (tx_pulse),
    .rx_pulse   (rx_pulse),
    .rx_sym     (rx_sym),
    .rx_link_ok (rx_link_ok)
);

// File: tb/iso_refresh_link_tb_top.sv
module iso_refresh_link_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] tx_sym = 2'b01;
    logic [1:0] tx_pulse;
    logic [1:0] rx_pulse;
    logic [1:0] rx_sym;
    logic       rx_link_ok;
    logic       loop_en = 1'b1;
    logic [1:0] inj_code = 2'b00;

    int tests = 0;
    int fails = 0;
    int pcount = 0;
    logic [1:0] plast = 2'b00;
    bit done = 0;

    always #10 clk = ~clk;

    assign rx_pulse = loop_en ? tx_pulse : inj_code;

    iso_refresh_link dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .tx_sym     (tx_sym),
        .tx_pulse   (tx_pulse),
        .rx_pulse   (rx_pulse),
        .rx_sym     (rx_sym),
        .rx_link_ok (rx_link_ok)
    );

    // {sym, bits, pulses, last code, rx_sym, link_ok}
    localparam logic [18:0] VEC [13] = '{
        {2'b01, 8'd11, 4'd0, 2'b00, 2'b00, 1'b0},
        {2'b01, 8'd1,  4'd1, 2'b01, 2'b00, 1'b0},
        {2'b01, 8'd12, 4'd1, 2'b01, 2'b01, 1'b1},
        {2'b10, 8'd3,  4'd1, 2'b10, 2'b10, 1'b1},
        {2'b10, 8'd9,  4'd0, 2'b00, 2'b10, 1'b1},
        {2'b10, 8'd1,  4'd1, 2'b10, 2'b10, 1'b1},
        {2'b00, 8'd2,  4'd1, 2'b11, 2'b00, 1'b1},
        {2'b11, 8'd13, 4'd1, 2'b11, 2'b00, 1'b1},
        {2'b01, 8'd1,  4'd1, 2'b01, 2'b01, 1'b1},
        {2'b01, 8'd11, 4'd0, 2'b00, 2'b01, 1'b1},
        {2'b10, 8'd1,  4'd1, 2'b10, 2'b10, 1'b1},
        {2'b10, 8'd11, 4'd0, 2'b00, 2'b10, 1'b1},
        {2'b10, 8'd1,  4'd1, 2'b10, 2'b10, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clk_step();
        @(negedge clk);
        if (tx_pulse != 2'b00) begin
            pcount++;
            plast = tx_pulse;
        end
    endtask

    task automatic run_bit(input logic [1:0] inj);
        bit_tick = 1'b1;
        inj_code = inj;
        clk_step();
        bit_tick = 1'b0;
        inj_code = 2'b00;
        repeat (3) clk_step();
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) run_bit(2'b00);
    endtask

    task automatic pulse_only(input logic [1:0] code);
        inj_code = code;
        clk_step();
        inj_code = 2'b00;
        clk_step();
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) clk_step();
        check("R1 reset tx_pulse", tx_pulse, 0);
        check("R1 reset rx_link_ok", rx_link_ok, 0);
        check("R1 reset rx_sym", rx_sym, 0);
        rst_n = 1'b1;

        // Vector walk: loopback on, transmit pattern and receive tracking.
        for (int v = 0; v < 13; v++) begin
            tx_sym = VEC[v][18:17];
            pcount = 0;
            plast  = 2'b00;
            run_bits(int'(VEC[v][16:9]));
            check($sformatf("R2/R3/R4/R5 vec %0d pulse count", v), pcount, int'(VEC[v][8:5]));
            if (VEC[v][8:5] != 0)
                check($sformatf("R2/R3/R5 vec %0d pulse code", v), plast, int'(VEC[v][4:3]));
            check($sformatf("R6 vec %0d rx_sym", v), rx_sym, int'(VEC[v][2:1]));
            check($sformatf("R9 vec %0d rx_link_ok", v), rx_link_ok, int'(VEC[v][0]));
        end

        // R7: cut the link, watchdog fires on the 36th quiet tick.
        loop_en = 1'b0;
        run_bits(35);
        check("R7 link still up after 35 ticks", rx_link_ok, 1);
        run_bits(1);
        check("R7 link down after 36 ticks", rx_link_ok, 0);
        check("R7 rx_sym default while down", rx_sym, 0);

        // R9: two pulses revalidate.
        pulse_only(2'b10);
        check("R9 one pulse not enough", rx_link_ok, 0);
        check("R9 rx_sym held at default", rx_sym, 0);
        pulse_only(2'b10);
        check("R9 second pulse revalidates", rx_link_ok, 1);
        check("R6 rx_sym follows K", rx_sym, 2);

        // R8: pulse on the expiring tick keeps the link.
        run_bits(35);
        run_bit(2'b01);
        check("R8 link kept by coincident pulse", rx_link_ok, 1);
        check("R8 rx_sym J", rx_sym, 1);
        run_bits(35);
        check("R8 count restarted, still up", rx_link_ok, 1);
        run_bits(1);
        check("R8 expires 36 ticks after pulse", rx_link_ok, 0);

        // R9: expiry between pulses discards the streak.
        pulse_only(2'b01);
        run_bits(36);
        pulse_only(2'b01);
        check("R9 streak broken by expiry", rx_link_ok, 0);
        pulse_only(2'b01);
        check("R9 streak complete", rx_link_ok, 1);
        check("R6 rx_sym J after revalidation", rx_sym, 1);

        // R1: reset mid-run.
        loop_en = 1'b1;
        tx_sym = 2'b00;
        rst_n = 1'b0;
        clk_step();
        clk_step();
        check("R1 mid reset tx_pulse", tx_pulse, 0);
        check("R1 mid reset rx_link_ok", rx_link_ok, 0);
        check("R1 mid reset rx_sym", rx_sym, 0);
        rst_n = 1'b1;
        pcount = 0;
        run_bits(1);
        check("R1/R2 change from J after reset", pcount, 1);
        check("R1/R2 code SE0 after reset", plast, 3);

        done = 1;
        report();
        $finish;
    end
endmodule